// File: doc/BRIEF.md
# Pass-Through Access Attention Controller

This block sits on the bridge side of a pass-through window between a host bus and add-on logic. An upstream address decoder hands it one decoded access at a time: the region number, the direction, a burst flag, the active-low byte enables and the address. The block registers that access and raises an active-low attention flag toward the add-on. It then follows the access until the add-on signals completion with its active-low ready input. The region, direction, burst and byte-status outputs qualify the pending access. They only carry meaning while attention is low, and they return to idle values once the access is complete.

The decoded access arrives on a valid/ready interface. `hit_ready` is high only while nothing is pending. A hit presented while `hit_ready` is low is stalled: the decoder must hold it until the ready is seen. While an access is pending, the add-on may pull an address-read strobe low. The stored address then appears on a shared 32-bit bus, and the bus is released one cycle after the strobe returns high. Each add-on write strobe marks the byte lanes it supplied. The byte status shows those lanes one cycle later.

Top module: `ptsig_top`

## Requirements
- R1: After reset, `attn_n` is 1, `hit_ready` is 1, `dq_oe` is 0, `be_stat` is 4'hF, `burst_n` is 1, and `region` and `dir_wr` are 0.
- R2: The block accepts an access on a rising edge where `hit_valid` and `hit_ready` are both 1. From that edge on, `attn_n` reads 0.
- R3: From the accept edge until completion, `region` equals the captured `hit_region`. `dir_wr` equals `hit_write` (1 = write, 0 = read), and `burst_n` equals `hit_burst_n` (0 = burst). These three outputs hold steady until completion.
- R4: On accept, `be_stat` takes `hit_be_n` (bit i = 0 means lane i is pending, so 4'h0 means all four pending). On each later edge where an access is pending and `addon_wr_n` is 0, the lanes with `addon_be_n` bit = 0 are set to 1 in `be_stat`. The change is visible after that edge.
- R5: On an edge where an access is pending and `addon_rdy_n` is 0, the access completes. After that edge, `attn_n` is 1, `hit_ready` is 1, and the status outputs return to their R1 values, even if a write strobe was sampled on the same edge.
- R6: While an access is pending, `hit_ready` is 0. A presented `hit_valid` changes no output.
- R7: While `addon_rdy_n` stays 1, a pending access stays pending for any number of cycles.
- R8: In any cycle where an access is pending and `addon_addr_rd_n` is 0, `dq_oe` is 1 and `dq` equals the captured address.
- R9: After a cycle in which R8 applied, `dq_oe` stays 1 for exactly one further cycle with the same address, unless the strobe is still low. This holds even if the access completed at that edge.
- R10: While idle, `addon_wr_n`, `addon_rdy_n` and `addon_addr_rd_n` have no effect. `attn_n`, `be_stat` and the other status outputs keep their idle values, and `dq_oe` stays 0 apart from the R9 release cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Add-on clock |
| rst_n | input | 1 | Active-low reset |
| hit_valid | input | 1 | Decoded access presented |
| hit_ready | output | 1 | Block can take an access |
| hit_region | input | 2 | Region number of the access |
| hit_write | input | 1 | 1 = write access, 0 = read |
| hit_burst_n | input | 1 | 0 = burst access |
| hit_be_n | input | 4 | Active-low byte enables of the access |
| hit_addr | input | 32 | Access address |
| addon_rdy_n | input | 1 | Active-low completion from add-on |
| addon_addr_rd_n | input | 1 | Active-low address-read strobe |
| addon_wr_n | input | 1 | Active-low add-on write strobe |
| addon_be_n | input | 4 | Active-low lanes supplied by the write |
| attn_n | output | 1 | Active-low attention, access pending |
| burst_n | output | 1 | Burst flag of the pending access |
| region | output | 2 | Region of the pending access |
| dir_wr | output | 1 | Direction of the pending access |
| be_stat | output | 4 | Lanes not yet supplied (0 = pending) |
| dq | output | 32 | Shared bus value, stored address when enabled |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The assertions assume that the decoder keeps a stalled hit stable, that every input is a known value after reset, and that the add-on's strobes are sampled only on rising edges. The bench changes all inputs at the falling edge only. It applies random hits, strobes and ready pulses with bias, so that accesses are sometimes held off for long stretches, sometimes complete at once, and strobes sometimes arrive while idle. Directed phases cover the completion edge that coincides with a write strobe, and an address strobe released in the same cycle as completion.

// File: rtl/ptsig_pkg.sv
package ptsig_pkg;
  localparam int REGION_W = 2;

  typedef struct packed {
    logic [REGION_W-1:0] region;
    logic                wr;
    logic                burst_n;
  } ptsig_status_t;

  localparam ptsig_status_t STATUS_IDLE = '{region: '0, wr: 1'b0, burst_n: 1'b1};
endpackage

// File: rtl/ptsig_access_slot.sv
module ptsig_access_slot
  import ptsig_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              done,
  input  ptsig_status_t     hit_status,
  input  logic [ADDR_W-1:0] hit_addr,
  output logic              pending,
  output ptsig_status_t     status,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      status  <= STATUS_IDLE;
      addr    <= '0;
    end else if (accept) begin
      pending <= 1'b1;
      status  <= hit_status;
      addr    <= hit_addr;
    end else if (done) begin
      pending <= 1'b0;
      status  <= STATUS_IDLE;
    end
  end
endmodule

// File: rtl/ptsig_lane_track.sv
module ptsig_lane_track #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             done,
  input  logic             wr_hit,
  input  logic [LANES-1:0] hit_be_n,
  input  logic [LANES-1:0] wr_be_n,
  output logic [LANES-1:0] be_stat
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   be_stat[g] <= 1'b1;
      else if (accept)              be_stat[g] <= hit_be_n[g];
      else if (done)                be_stat[g] <= 1'b1;
      else if (wr_hit && !wr_be_n[g]) be_stat[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/ptsig_bus_drive.sv
module ptsig_bus_drive #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pending,
  input  logic              addr_rd_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] dq,
  output logic              dq_oe
);
  logic strobe_now;
  logic hold_q;

  assign strobe_now = pending && !addr_rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= strobe_now;
  end

  assign dq_oe = strobe_now || hold_q;
  assign dq    = dq_oe ? addr : '0;
endmodule

// File: rtl/ptsig_top.sv
module ptsig_top
  import ptsig_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hit_valid,
  output logic                hit_ready,
  input  logic [REGION_W-1:0] hit_region,
  input  logic                hit_write,
  input  logic                hit_burst_n,
  input  logic [LANES-1:0]    hit_be_n,
  input  logic [ADDR_W-1:0]   hit_addr,
  input  logic                addon_rdy_n,
  input  logic                addon_addr_rd_n,
  input  logic                addon_wr_n,
  input  logic [LANES-1:0]    addon_be_n,
  output logic                attn_n,
  output logic                burst_n,
  output logic [REGION_W-1:0] region,
  output logic                dir_wr,
  output logic [LANES-1:0]    be_stat,
  output logic [ADDR_W-1:0]   dq,
  output logic                dq_oe
);
  logic              pending;
  logic              accept;
  logic              done;
  ptsig_status_t     hit_status;
  ptsig_status_t     status;
  logic [ADDR_W-1:0] addr_q;

  assign hit_ready  = !pending;
  assign accept     = hit_valid && hit_ready;
  assign done       = pending && !addon_rdy_n;
  assign hit_status = '{region: hit_region, wr: hit_write, burst_n: hit_burst_n};

  ptsig_access_slot #(.ADDR_W(ADDR_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .accept(accept), .done(done),
    .hit_status(hit_status), .hit_addr(hit_addr),
    .pending(pending), .status(status), .addr(addr_q)
  );

  ptsig_lane_track #(.LANES(LANES)) u_lanes (
    .clk(clk), .rst_n(rst_n), .accept(accept), .done(done),
    .wr_hit(pending && !addon_wr_n), .hit_be_n(hit_be_n),
    .wr_be_n(addon_be_n), .be_stat(be_stat)
  );

  ptsig_bus_drive #(.ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .pending(pending),
    .addr_rd_n(addon_addr_rd_n), .addr(addr_q), .dq(dq), .dq_oe(dq_oe)
  );

  assign attn_n  = !pending;
  assign burst_n = status.burst_n;
  assign region  = status.region;
  assign dir_wr  = status.wr;
endmodule

// File: rtl/ptsig_checker.sv
module ptsig_checker #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hit_valid,
  input logic             hit_ready,
  input logic             addon_rdy_n,
  input logic             addon_addr_rd_n,
  input logic             attn_n,
  input logic             burst_n,
  input logic [1:0]       region,
  input logic             dir_wr,
  input logic [LANES-1:0] be_stat,
  input logic             dq_oe
);
  AST_ACCEPT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid && hit_ready |=> !attn_n); // R2
  AST_STATUS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !attn_n && addon_rdy_n |=> $stable(region) && $stable(dir_wr) && $stable(burst_n)); // R3
  AST_LANES_ONLY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !attn_n && addon_rdy_n |=> (be_stat & $past(be_stat)) == $past(be_stat)); // R4
  AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !attn_n && !addon_rdy_n |=> attn_n && hit_ready); // R5
  AST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !attn_n |-> !hit_ready); // R6
  AST_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    !attn_n && addon_rdy_n |=> !attn_n); // R7
  AST_ADDR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !attn_n && !addon_addr_rd_n |-> dq_oe); // R8
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe && addon_addr_rd_n |=> !dq_oe || !addon_addr_rd_n); // R9
  AST_IDLE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    attn_n |-> be_stat == '1 && burst_n && !dir_wr && region == 2'd0); // R10
endmodule

bind ptsig_top ptsig_checker #(.LANES(LANES)) i_ptsig_checker (
  .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_ready(hit_ready),
  .addon_rdy_n(addon_rdy_n), .addon_addr_rd_n(addon_addr_rd_n),
  .attn_n(attn_n), .burst_n(burst_n), .region(region), .dir_wr(dir_wr),
  .be_stat(be_stat), .dq_oe(dq_oe)
);

// File: tb/test_ptsig_top.sv
module test_ptsig_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hit_valid = 1'b0;
  logic        hit_ready;
  logic [1:0]  hit_region = '0;
  logic        hit_write = 1'b0;
  logic        hit_burst_n = 1'b1;
  logic [3:0]  hit_be_n = '0;
  logic [31:0] hit_addr = '0;
  logic        addon_rdy_n = 1'b1;
  logic        addon_addr_rd_n = 1'b1;
  logic        addon_wr_n = 1'b1;
  logic [3:0]  addon_be_n = 4'hF;
  logic        attn_n, burst_n, dir_wr, dq_oe;
  logic [1:0]  region;
  logic [3:0]  be_stat;
  logic [31:0] dq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done_run = 1'b0;

  // expected-state model, built from the requirements
  logic        m_pend = 0, m_wr = 0, m_burst_n = 1, m_hold = 0;
  logic [1:0]  m_region = 0;
  logic [3:0]  m_be = 4'hF;
  logic [31:0] m_addr = 0;

  always #5 clk = ~clk;

  ptsig_top i_ptsig_top (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_ready(hit_ready),
    .hit_region(hit_region), .hit_write(hit_write), .hit_burst_n(hit_burst_n),
    .hit_be_n(hit_be_n), .hit_addr(hit_addr), .addon_rdy_n(addon_rdy_n),
    .addon_addr_rd_n(addon_addr_rd_n), .addon_wr_n(addon_wr_n),
    .addon_be_n(addon_be_n), .attn_n(attn_n), .burst_n(burst_n),
    .region(region), .dir_wr(dir_wr), .be_stat(be_stat), .dq(dq), .dq_oe(dq_oe)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      m_hold <= m_pend && !addon_addr_rd_n;
      if (!m_pend) begin
        if (hit_valid) begin
          m_pend <= 1; m_region <= hit_region; m_wr <= hit_write;
          m_burst_n <= hit_burst_n; m_be <= hit_be_n; m_addr <= hit_addr;
        end
      end else if (!addon_rdy_n) begin
        m_pend <= 0; m_region <= 0; m_wr <= 0; m_burst_n <= 1; m_be <= 4'hF;
      end else if (!addon_wr_n) begin
        m_be <= m_be | ~addon_be_n;
      end
    end
  end

  function automatic logic exp_oe();
    return (m_pend && !addon_addr_rd_n) || m_hold;
  endfunction

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // called after inputs settle in the low phase
  task automatic compare();
    check(m_pend ? "R2" : "R5", "attn_n", 32'(attn_n), 32'(!m_pend));
    check("R6", "hit_ready", 32'(hit_ready), 32'(!m_pend));
    check("R3", "region", 32'(region), 32'(m_region));
    check("R3", "dir_wr", 32'(dir_wr), 32'(m_wr));
    check("R3", "burst_n", 32'(burst_n), 32'(m_burst_n));
    check(m_pend ? "R4" : "R10", "be_stat", 32'(be_stat), 32'(m_be));
    check(m_hold ? "R9" : (m_pend ? "R8" : "R10"), "dq_oe", 32'(dq_oe), 32'(exp_oe()));
    if (exp_oe()) check("R8", "dq", dq, m_addr);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    hit_valid = 0; addon_rdy_n = 1; addon_addr_rd_n = 1; addon_wr_n = 1; addon_be_n = 4'hF;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done_run) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", "attn_n", 32'(attn_n), 1);
    check("R1", "hit_ready", 32'(hit_ready), 1);
    check("R1", "dq_oe", 32'(dq_oe), 0);
    check("R1", "be_stat", 32'(be_stat), 32'hF);
    check("R1", "burst_n", 32'(burst_n), 1);
    rst_n = 1;
    step();
    // R10: strobes while idle
    addon_wr_n = 0; addon_be_n = 4'h0; addon_rdy_n = 0; addon_addr_rd_n = 0;
    #1 compare(); step(); #1 compare();
    quiet();
    // R2/R3: read of region 2, all lanes pending
    hit_valid = 1; hit_region = 2'd2; hit_write = 0; hit_burst_n = 1;
    hit_be_n = 4'h0; hit_addr = 32'hCAFE_0010;
    #1 compare(); step();
    hit_valid = 1; hit_region = 2'd1; hit_addr = 32'h1111_2222; // R6 stalled hit
    #1 compare();
    check("R2", "attn_n after accept", 32'(attn_n), 0);
    check("R3", "region captured", 32'(region), 2);
    // R7: hold off ready for a long stretch
    for (int i = 0; i < 20; i++) begin step(); #1 compare(); end
    check("R7", "attn_n held", 32'(attn_n), 0);
    check("R6", "stall kept region", 32'(region), 2);
    hit_valid = 0;
    // R8/R9: address strobe one cycle
    addon_addr_rd_n = 0; #1 compare();
    check("R8", "dq address", dq, 32'hCAFE_0010);
    step(); addon_addr_rd_n = 1; #1 compare();
    check("R9", "dq_oe release cycle", 32'(dq_oe), 1);
    step(); #1 compare();
    check("R9", "dq_oe released", 32'(dq_oe), 0);
    // R4: write lanes 0 and 1
    addon_wr_n = 0; addon_be_n = 4'hC; #1 compare(); step();
    addon_wr_n = 1; addon_be_n = 4'hF; #1 compare();
    check("R4", "be_stat after write", 32'(be_stat), 32'h3);
    // R5: completion with write and address strobe on the same edge
    addon_wr_n = 0; addon_be_n = 4'h3; addon_rdy_n = 0; addon_addr_rd_n = 0;
    #1 compare(); step(); quiet(); #1 compare();
    check("R5", "attn_n after ready", 32'(attn_n), 1);
    check("R5", "be_stat idle", 32'(be_stat), 32'hF);
    check("R9", "dq_oe after completion", 32'(dq_oe), 1);
    step(); #1 compare();
    // random phase
    for (int c = 0; c < 4000; c++) begin
      hit_valid       = ($urandom % 3) == 0;
      hit_region      = 2'($urandom);
      hit_write       = 1'($urandom);
      hit_burst_n     = 1'($urandom);
      hit_be_n        = 4'($urandom);
      hit_addr        = $urandom;
      addon_rdy_n     = ($urandom % 6) != 0;
      addon_addr_rd_n = ($urandom % 4) != 0;
      addon_wr_n      = ($urandom % 3) != 0;
      addon_be_n      = 4'($urandom);
      #1 compare();
      step();
    end
    done_run = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule